// File: doc/BRIEF.md
# Windowed Integer Register File

This block is the integer register file of a 32-bit core. It holds a small bank of global registers and a pool of 64 physical local registers. A 5-bit register index addresses both. Indices 0 to 9 reach the globals. Indices 10 to 31 reach 22 local slots, and those slots slide over the pool as the window base moves. Two combinational read ports and one clocked write port serve the datapath. Globals 1 to 3 hold the program counter, loop counter and stack pointer, and they are also brought out on dedicated debug taps.

Frame management stands in for the window-allocate instruction and its matching return. A request carries a size and a direction. A grow request advances the window base by its size. A shrink request moves the base back by the same amount. Frames may be larger than the 22 visible local slots, up to the whole pool. A programmable part of the pool is held back for interrupt handlers. An ordinary grow that would reach into that part is refused with a one-cycle spill fault. A grow made with the interrupt flag set may use the held-back part. A shrink larger than what is allocated is refused with a one-cycle underflow fault.

Top module: `windowed_regfile`

## Requirements
- R1: An index of 10 or more selects local slot k = index - 10, stored at physical entry (base + k) mod 64, where base is the current window base.
- R2: Index 0 always reads as zero, and writes to index 0 are discarded.
- R3: The debug taps `dbg_pc`, `dbg_lc` and `dbg_sp` always show globals 1, 2 and 3.
- R4: Reads are combinational. A read of the entry being written in the same cycle returns the old value, and the new value is readable from the cycle after the clock edge.
- R5: A grow request (`win_req`=1, `win_rel`=0) with the interrupt flag low succeeds when its size is at most max(free - reserve, 0). At the next edge, base increases by the size and free decreases by the size.
- R6: A grow request that does not fit raises `spill_o` for exactly the cycle after the request and leaves base and free unchanged.
- R7: A grow request with `in_irq`=1 ignores the reserve. It succeeds whenever its size is at most free, so a size within the reserve never spills while the reserve is still free. Otherwise it spills as in R6.
- R8: A shrink request (`win_req`=1, `win_rel`=1) with size at most base lowers base and raises free by the size. A larger size raises `underflow_o` for one cycle and changes nothing.
- R9: `rsv_we`=1 loads `rsv_val` into the reserve at the clock edge, and later grow requests use the new value.
- R10: Reset clears the globals, sets base to 0, free to 64 and the reserve to 0, and holds both faults low.
- R11: Frames larger than 22 registers (jumbo frames) are accepted, up to the free count.
- R12: A request of size 0 in either direction changes nothing and raises no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ra_idx | input | 5 | Read port A index |
| ra_data | output | 32 | Read port A data |
| rb_idx | input | 5 | Read port B index |
| rb_data | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 5 | Write index |
| wr_data | input | 32 | Write data |
| win_req | input | 1 | Frame request valid |
| win_rel | input | 1 | 1 = shrink (release), 0 = grow (allocate) |
| win_size | input | 7 | Frame size in registers |
| in_irq | input | 1 | Request is made in interrupt context |
| rsv_we | input | 1 | Load the interrupt reserve |
| rsv_val | input | 7 | New reserve size |
| spill_o | output | 1 | Grow refused, one-cycle pulse |
| underflow_o | output | 1 | Shrink refused, one-cycle pulse |
| base_o | output | 7 | Current window base |
| free_o | output | 7 | Free physical local registers |
| dbg_pc | output | 32 | Global 1 tap |
| dbg_lc | output | 32 | Global 2 tap |
| dbg_sp | output | 32 | Global 3 tap |

## Verification
Read data is due in the same cycle as its index. It is sampled one nanosecond after the inputs change and is compared with the mapping through the base as it stood before that edge. A write, a base or free update, a reserve load and a fault pulse are all due one edge later. The bench advances its model at the rising edge and compares those outputs at the following falling edge. A fault is checked to be high there and low again one cycle on. Ignored writes and refused requests are confirmed through later reads and through the base and free outputs.

// File: rtl/wrf_pkg.sv
package wrf_pkg;
  localparam int unsigned DEF_XLEN  = 32;
  localparam int unsigned DEF_IDXW  = 5;
  localparam int unsigned DEF_NGLOB = 10;
  localparam int unsigned DEF_POOL  = 64;

  typedef enum logic [1:0] {
    WIN_IDLE   = 2'd0,
    WIN_GROW   = 2'd1,
    WIN_SHRINK = 2'd2
  } win_op_e;
endpackage

// File: rtl/wrf_global_bank.sv
module wrf_global_bank #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned NGLOB = 10,
  parameter int unsigned GIDXW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [GIDXW-1:0] widx_i,
  input  logic [XLEN-1:0]  wdata_i,
  input  logic [GIDXW-1:0] raidx_i,
  output logic [XLEN-1:0]  rdata_a_o,
  input  logic [GIDXW-1:0] rbidx_i,
  output logic [XLEN-1:0]  rdata_b_o,
  output logic [XLEN-1:0]  tap1_o,
  output logic [XLEN-1:0]  tap2_o,
  output logic [XLEN-1:0]  tap3_o
);
  localparam logic [GIDXW-1:0] NG_I = GIDXW'(NGLOB);

  logic [XLEN-1:0] g_rd [NGLOB];

  for (genvar i = 0; i < NGLOB; i++) begin : g_ent
    if (i == 0) begin : g_zero
      assign g_rd[i] = '0;
    end else begin : g_reg
      logic            en;
      logic [XLEN-1:0] q;
      always_comb en = we_i && (widx_i == GIDXW'(i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= wdata_i;
      end
      assign g_rd[i] = q;
    end
  end

  always_comb begin
    rdata_a_o = (raidx_i < NG_I) ? g_rd[raidx_i] : '0;
    rdata_b_o = (rbidx_i < NG_I) ? g_rd[rbidx_i] : '0;
  end

  assign tap1_o = g_rd[1];
  assign tap2_o = g_rd[2];
  assign tap3_o = g_rd[3];

  // R3: a tap moves only when its own register is written
  a_r3_tap1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && widx_i == GIDXW'(1)) |=> $stable(tap1_o));
  a_r3_tap3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(we_i && widx_i == GIDXW'(3)) |=> $stable(tap3_o));
endmodule

// File: rtl/wrf_local_pool.sv
module wrf_local_pool #(
  parameter int unsigned XLEN  = 32,
  parameter int unsigned POOL  = 64,
  parameter int unsigned PIDXW = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [PIDXW-1:0] widx_i,
  input  logic [XLEN-1:0]  wdata_i,
  input  logic [PIDXW-1:0] raidx_i,
  output logic [XLEN-1:0]  rdata_a_o,
  input  logic [PIDXW-1:0] rbidx_i,
  output logic [XLEN-1:0]  rdata_b_o
);
  logic [XLEN-1:0] mem [POOL];

  always_ff @(posedge clk) begin
    if (we_i) mem[widx_i] <= wdata_i;
  end

  always_comb begin
    rdata_a_o = mem[raidx_i];
    rdata_b_o = mem[rbidx_i];
  end

  // R4: a write is readable on the port one edge later
  a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && raidx_i == widx_i) |=> ($stable(raidx_i) && !$past(we_i, 1) == 1'b0) |-> rdata_a_o == $past(wdata_i));
endmodule

// File: rtl/wrf_window_ctrl.sv
module wrf_window_ctrl
  import wrf_pkg::*;
#(
  parameter int unsigned POOL = 64,
  parameter int unsigned CNTW = 7
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_i,
  input  logic            rel_i,
  input  logic [CNTW-1:0] size_i,
  input  logic            irq_i,
  input  logic            rsv_we_i,
  input  logic [CNTW-1:0] rsv_val_i,
  output logic [CNTW-1:0] base_o,
  output logic [CNTW-1:0] free_o,
  output logic            spill_o,
  output logic            underflow_o
);
  localparam logic [CNTW-1:0] POOL_C = CNTW'(POOL);

  win_op_e         op;
  logic [CNTW-1:0] base_q, base_d, free_q, free_d, rsv_q, avail;
  logic            base_en, fits, spill_q, spill_d, uf_q, uf_d;

  always_comb begin
    if (!req_i)     op = WIN_IDLE;
    else if (rel_i) op = WIN_SHRINK;
    else            op = WIN_GROW;
  end

  // room a grow may take: the whole free count in a handler, otherwise
  // only what lies above the interrupt reserve
  always_comb begin
    if (irq_i)               avail = free_q;
    else if (free_q > rsv_q) avail = free_q - rsv_q;
    else                     avail = '0;
  end

  always_comb begin
    base_d  = base_q;
    free_d  = free_q;
    base_en = 1'b0;
    spill_d = 1'b0;
    uf_d    = 1'b0;
    fits    = 1'b0;
    unique case (op)
      WIN_GROW: begin
        fits    = (size_i <= avail);
        spill_d = !fits;
        base_en = fits;
        base_d  = base_q + size_i;
        free_d  = free_q - size_i;
      end
      WIN_SHRINK: begin
        fits    = (size_i <= base_q);
        uf_d    = !fits;
        base_en = fits;
        base_d  = base_q - size_i;
        free_d  = free_q + size_i;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      free_q  <= POOL_C;
      rsv_q   <= '0;
      spill_q <= 1'b0;
      uf_q    <= 1'b0;
    end else begin
      if (base_en) begin
        base_q <= base_d;
        free_q <= free_d;
      end
      if (rsv_we_i) rsv_q <= rsv_val_i;
      spill_q <= spill_d;
      uf_q    <= uf_d;
    end
  end

  assign base_o      = base_q;
  assign free_o      = free_q;
  assign spill_o     = spill_q;
  assign underflow_o = uf_q;

  // R5: base and free always account for the whole pool
  a_r5_pool_conserved: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, free_q} + {1'b0, base_q}) == (CNTW+1)'(POOL));
  // R6: a refused grow leaves the window where it was
  a_r6_spill_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spill_q) |-> (base_q == $past(base_q)));
  // R8: a refused shrink leaves the window where it was
  a_r8_underflow_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uf_q) |-> (base_q == $past(base_q)));
  a_r8_one_fault: assert property (@(posedge clk) disable iff (!rst_n)
    !(spill_q && uf_q));
  // R7: a handler grow within a still-free reserve never spills
  a_r7_irq_no_spill: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && !rel_i && irq_i && size_i <= rsv_q && free_q >= rsv_q) |=> !spill_q);
  // R12: a zero-size request never faults
  a_r12_zero_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (req_i && size_i == '0) |=> (!spill_q && !uf_q));
endmodule

// File: rtl/windowed_regfile.sv
module windowed_regfile
  import wrf_pkg::*;
#(
  parameter int unsigned XLEN  = DEF_XLEN,
  parameter int unsigned IDXW  = DEF_IDXW,
  parameter int unsigned NGLOB = DEF_NGLOB,
  parameter int unsigned POOL  = DEF_POOL
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [IDXW-1:0] ra_idx,
  output logic [XLEN-1:0] ra_data,
  input  logic [IDXW-1:0] rb_idx,
  output logic [XLEN-1:0] rb_data,
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            win_req,
  input  logic            win_rel,
  input  logic [$clog2(POOL+1)-1:0] win_size,
  input  logic            in_irq,
  input  logic            rsv_we,
  input  logic [$clog2(POOL+1)-1:0] rsv_val,
  output logic            spill_o,
  output logic            underflow_o,
  output logic [$clog2(POOL+1)-1:0] base_o,
  output logic [$clog2(POOL+1)-1:0] free_o,
  output logic [XLEN-1:0] dbg_pc,
  output logic [XLEN-1:0] dbg_lc,
  output logic [XLEN-1:0] dbg_sp
);
  localparam int unsigned CNTW  = $clog2(POOL+1);
  localparam int unsigned PIDXW = $clog2(POOL);
  localparam int unsigned GIDXW = $clog2(NGLOB);
  localparam logic [IDXW-1:0] NG_I = IDXW'(NGLOB);

  logic [CNTW-1:0]  base;
  logic             ra_loc, rb_loc, wr_loc;
  logic [PIDXW-1:0] ra_phys, rb_phys, wr_phys;
  logic [XLEN-1:0]  g_a, g_b, p_a, p_b;

  function automatic logic [PIDXW-1:0] to_phys(input logic [IDXW-1:0] idx,
                                               input logic [CNTW-1:0] b);
    logic [CNTW:0] s;
    s = {1'b0, b} + (CNTW+1)'(idx - NG_I);
    if (s >= (CNTW+1)'(POOL)) s = s - (CNTW+1)'(POOL);
    return s[PIDXW-1:0];
  endfunction

  always_comb begin
    ra_loc  = (ra_idx >= NG_I);
    rb_loc  = (rb_idx >= NG_I);
    wr_loc  = (wr_idx >= NG_I);
    ra_phys = to_phys(ra_idx, base);
    rb_phys = to_phys(rb_idx, base);
    wr_phys = to_phys(wr_idx, base);
  end

  wrf_global_bank #(.XLEN(XLEN), .NGLOB(NGLOB), .GIDXW(GIDXW)) i_glob (
    .clk(clk), .rst_n(rst_n),
    .we_i(wr_en && !wr_loc), .widx_i(wr_idx[GIDXW-1:0]), .wdata_i(wr_data),
    .raidx_i(ra_idx[GIDXW-1:0]), .rdata_a_o(g_a),
    .rbidx_i(rb_idx[GIDXW-1:0]), .rdata_b_o(g_b),
    .tap1_o(dbg_pc), .tap2_o(dbg_lc), .tap3_o(dbg_sp)
  );

  wrf_local_pool #(.XLEN(XLEN), .POOL(POOL), .PIDXW(PIDXW)) i_pool (
    .clk(clk), .rst_n(rst_n),
    .we_i(wr_en && wr_loc), .widx_i(wr_phys), .wdata_i(wr_data),
    .raidx_i(ra_phys), .rdata_a_o(p_a),
    .rbidx_i(rb_phys), .rdata_b_o(p_b)
  );

  wrf_window_ctrl #(.POOL(POOL), .CNTW(CNTW)) i_win (
    .clk(clk), .rst_n(rst_n),
    .req_i(win_req), .rel_i(win_rel), .size_i(win_size), .irq_i(in_irq),
    .rsv_we_i(rsv_we), .rsv_val_i(rsv_val),
    .base_o(base), .free_o(free_o), .spill_o(spill_o), .underflow_o(underflow_o)
  );

  assign base_o  = base;
  assign ra_data = ra_loc ? p_a : g_a;
  assign rb_data = rb_loc ? p_b : g_b;

  // R2: index zero reads as zero on both ports
  a_r2_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_idx == '0) |-> (ra_data == '0));
  a_r2_zero_read_b: assert property (@(posedge clk) disable iff (!rst_n)
    (rb_idx == '0) |-> (rb_data == '0));
  // R1: a write through a local index under a steady base is read back there
  a_r1_local_roundtrip: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_loc && ra_idx == wr_idx && !win_req) |=>
      ($stable(ra_idx) && !$past(wr_en, 2)) |-> ra_data == $past(wr_data));
endmodule

// File: tb/test_windowed_regfile.sv
`timescale 1ns/1ps
module test_windowed_regfile;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  ra_idx, rb_idx, wr_idx;
  logic [31:0] ra_data, rb_data, wr_data;
  logic        wr_en, win_req, win_rel, in_irq, rsv_we;
  logic [6:0]  win_size, rsv_val, base_o, free_o;
  logic        spill_o, underflow_o;
  logic [31:0] dbg_pc, dbg_lc, dbg_sp;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [31:0] gm [10];
  logic [31:0] pm [64];
  bit          pv [64];
  int          mbase, mfree, mrsv;
  bit          exp_spill, exp_uf;

  always #2.5 clk = ~clk;

  windowed_regfile i_windowed_regfile (
    .clk(clk), .rst_n(rst_n),
    .ra_idx(ra_idx), .ra_data(ra_data), .rb_idx(rb_idx), .rb_data(rb_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .win_req(win_req), .win_rel(win_rel), .win_size(win_size), .in_irq(in_irq),
    .rsv_we(rsv_we), .rsv_val(rsv_val),
    .spill_o(spill_o), .underflow_o(underflow_o), .base_o(base_o), .free_o(free_o),
    .dbg_pc(dbg_pc), .dbg_lc(dbg_lc), .dbg_sp(dbg_sp)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int phys_of(int idx);
    return (mbase + idx - 10) % 64;
  endfunction

  task automatic chk_read(int idx, logic [31:0] act);
    if (idx == 0) chk("R2", act, 32'h0);
    else if (idx < 10) chk("R4", act, gm[idx]);
    else if (pv[phys_of(idx)]) chk("R1", act, pm[phys_of(idx)]);
  endtask

  // one cycle: entered at a falling edge, left at the next falling edge
  task automatic cyc(bit w, int wi, logic [31:0] wd, bit rq, bit rl, int sz,
                     bit irq, bit rw, int rv, int ra, int rb);
    int avail;
    wr_en = w; wr_idx = 5'(wi); wr_data = wd;
    win_req = rq; win_rel = rl; win_size = 7'(sz); in_irq = irq;
    rsv_we = rw; rsv_val = 7'(rv);
    ra_idx = 5'(ra); rb_idx = 5'(rb);
    #1;
    chk_read(ra, ra_data);
    chk_read(rb, rb_data);
    avail = irq ? mfree : (mfree > mrsv ? mfree - mrsv : 0);
    exp_spill = rq && !rl && (sz > avail);
    exp_uf    = rq && rl && (sz > mbase);
    @(posedge clk);
    if (w && wi != 0) begin
      if (wi < 10) gm[wi] = wd;
      else begin pm[phys_of(wi)] = wd; pv[phys_of(wi)] = 1'b1; end
    end
    if (rq && !rl && !exp_spill) begin mbase += sz; mfree -= sz; end
    if (rq && rl && !exp_uf)     begin mbase -= sz; mfree += sz; end
    if (rw) mrsv = rv;
    @(negedge clk);
    chk(irq ? "R7" : "R6", {31'b0, spill_o}, {31'b0, exp_spill});
    chk("R8", {31'b0, underflow_o}, {31'b0, exp_uf});
    chk("R5", {25'b0, base_o}, 32'(mbase));
    chk("R5", {25'b0, free_o}, 32'(mfree));
    chk("R3", dbg_pc, gm[1]);
    chk("R3", dbg_sp, gm[3]);
  endtask

  task automatic idle(int ra, int rb);
    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, ra, rb);
  endtask

  initial begin
    #1000000;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    wr_en = 0; wr_idx = 0; wr_data = 0; win_req = 0; win_rel = 0; win_size = 0;
    in_irq = 0; rsv_we = 0; rsv_val = 0; ra_idx = 5; rb_idx = 3;
    for (int i = 0; i < 10; i++) gm[i] = 32'h0;
    for (int i = 0; i < 64; i++) begin pm[i] = 32'h0; pv[i] = 1'b0; end
    mbase = 0; mfree = 64; mrsv = 0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk("R10", {25'b0, base_o}, 32'd0);
    chk("R10", {25'b0, free_o}, 32'd64);
    chk("R10", {30'b0, spill_o, underflow_o}, 32'd0);
    chk("R10", ra_data, 32'd0);
    chk("R10", dbg_lc, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2: write to index 0 discarded
    cyc(1, 0, 32'hDEADBEEF, 0, 0, 0, 0, 0, 0, 0, 0);
    idle(0, 0);
    // R3: taps follow globals 1..3
    cyc(1, 1, 32'h1000, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 2, 32'h2000, 0, 0, 0, 0, 0, 0, 0, 0);
    cyc(1, 3, 32'h3000, 0, 0, 0, 0, 0, 0, 0, 0);
    chk("R3", dbg_lc, 32'h2000);
    // R4: read during write returns the old value, new one next cycle
    cyc(1, 5, 32'hA5A5A5A5, 0, 0, 0, 0, 0, 0, 5, 5);
    idle(5, 5);
    chk("R4", ra_data, 32'hA5A5A5A5);
    cyc(1, 10, 32'h0BAD0000, 0, 0, 0, 0, 0, 0, 10, 31);
    // R11: jumbo frame of 40
    cyc(0, 0, 0, 1, 0, 40, 0, 0, 0, 10, 10);
    chk("R11", {25'b0, base_o}, 32'd40);
    cyc(1, 10, 32'h40404040, 0, 0, 0, 0, 0, 0, 10, 31);
    cyc(1, 31, 32'h61616161, 0, 0, 0, 0, 0, 0, 10, 31);
    idle(10, 31);
    // R1: release returns to the older window, its slot intact
    cyc(0, 0, 0, 1, 1, 40, 0, 0, 0, 10, 10);
    #1;
    chk("R1", ra_data, 32'h0BAD0000);
    // R9: reserve of 10, then a grow of 60 spills
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 10, 0, 0);
    cyc(0, 0, 0, 1, 0, 60, 0, 0, 0, 0, 0);
    chk("R9", {31'b0, spill_o}, 32'd1);
    idle(0, 0);
    chk("R6", {31'b0, spill_o}, 32'd0);
    cyc(0, 0, 0, 1, 0, 54, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0);
    chk("R6", {31'b0, spill_o}, 32'd1);
    // R7: handler grow uses the reserve
    cyc(0, 0, 0, 1, 0, 10, 1, 0, 0, 0, 0);
    chk("R7", {31'b0, spill_o}, 32'd0);
    cyc(0, 0, 0, 1, 0, 1, 1, 0, 0, 0, 0);
    // R8: full release then an underflow
    cyc(0, 0, 0, 1, 1, 64, 0, 0, 0, 0, 0);
    cyc(0, 0, 0, 1, 1, 1, 0, 0, 0, 0, 0);
    chk("R8", {31'b0, underflow_o}, 32'd1);
    // R12: zero-size requests are quiet
    cyc(0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0);
    chk("R12", {30'b0, spill_o, underflow_o}, 32'd0);
    cyc(0, 0, 0, 1, 0, 0, 0, 0, 0, 0, 0);
    chk("R12", {25'b0, base_o}, 32'd0);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      int sz;
      sz = (($urandom % 16) == 0) ? int'($urandom % 70) : int'($urandom % 9);
      cyc(($urandom % 2) == 1, int'($urandom % 32), $urandom,
          ($urandom % 3) == 0, ($urandom % 2) == 1, sz,
          ($urandom % 4) == 0, ($urandom % 32) == 0, int'($urandom % 20),
          int'($urandom % 32), int'($urandom % 32));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule